// File: doc/BRIEF.md
# Three-Slot Shifting Token Queue

This block is a very short first-in first-out buffer that carries tokens from one pipeline to another. It has no read or write pointers. Its storage is a chain of registers, and each register has its own occupancy flag. Every token enters at the input end of the chain. It moves one slot toward the output end in any cycle where the slot ahead of it is free or is being freed in that same cycle. A one-hot multiplexer, steered by the flags, shows the oldest held token on the output together with a valid bit.

The producer offers a token with a valid bit in every cycle. It must hold back while `full` is high. The consumer takes the shown token by pulsing `deq`. `full` is combinational in `deq`, so a producer that sees `full` low may send a token in the same cycle as a dequeue from a full queue. A synchronous `flush` empties the queue in one cycle.

Top module: `shift_token_queue`

## Requirements
- R1: After reset, `out_valid` is 0 and `full` is 0.
- R2: Tokens leave in the order they were accepted. Each accepted token is shown exactly once, until the cycle in which `deq` removes it. The shown token does not change while `deq` is low.
- R3: A token offered with `in_valid` high to an empty queue, with `flush` low, is shown on `out_valid`/`out_data` starting from the next clock cycle.
- R4: The queue holds exactly three tokens. After three tokens are accepted with no dequeue, `full` is high.
- R5: `full` is high exactly when three tokens are held and `deq` is low in the same cycle. With three tokens held and `deq` high, `full` is low and a token offered in that cycle is accepted.
- R6: A token offered while `full` is high is dropped. The three held tokens and their order stay unchanged.
- R7: `deq` while `out_valid` is low removes nothing. Tokens accepted afterwards are delivered normally.
- R8: `flush` high at a clock edge empties the queue. A token offered in that same cycle is discarded, and `flush` takes priority over `deq`.
- R9: `out_valid` is high exactly when at least one token is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all entries |
| in_valid | input | 1 | Input token present |
| in_data | input | DATA_W | Input token payload |
| full | output | 1 | Three tokens held and no dequeue this cycle |
| deq | input | 1 | Consumer takes the shown token |
| out_valid | output | 1 | A token is shown on out_data |
| out_data | output | DATA_W | Oldest held token |

## Verification
The bench builds the queue with its default three slots and a 12-bit payload. It numbers tokens from a running counter, so a lost, duplicated or reordered token shows up as a payload mismatch against the behavioural model. The three-slot depth means random traffic reaches the full state often. It also often combines dequeue-while-full with a new write, so the full-inhibit path and the combinational `full`/`deq` path both get exercised. This comes on top of the directed sequences for overfill, flush and dequeue from an empty queue.

// File: rtl/stq_pkg.sv
package stq_pkg;
   // What a storage slot does at the next clock edge
   typedef enum logic [1:0] {
      SLOT_HOLD  = 2'd0,
      SLOT_LOAD  = 2'd1,
      SLOT_CLEAR = 2'd2
   } slot_act_e;
endpackage

// File: rtl/stq_slot.sv
module stq_slot
   import stq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slot_act_e         act,
   input  logic              ld_valid,
   input  logic [DATA_W-1:0] ld_data,
   output logic              valid_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         unique case (act)
            SLOT_LOAD: begin
               valid_q <= ld_valid;
               data_q  <= ld_data;
            end
            SLOT_CLEAR: valid_q <= 1'b0;
            default:    valid_q <= valid_q;
         endcase
      end
   end
endmodule

// File: rtl/stq_flow_ctrl.sv
module stq_flow_ctrl
   import stq_pkg::*;
#(
   parameter int NUM_SLOTS = 3
) (
   input  logic [NUM_SLOTS-1:0]            valid_q,
   input  logic                            deq,
   input  logic                            flush,
   output logic [NUM_SLOTS-1:0]            sel_oh,
   output logic                            any_valid,
   output logic                            full,
   output slot_act_e [NUM_SLOTS-1:0]       act
);
   localparam int TOP = NUM_SLOTS - 1;

   logic                 take;
   logic                 vac_up;
   logic [NUM_SLOTS-1:0] pop;
   logic [NUM_SLOTS-1:0] mv;
   logic [NUM_SLOTS-1:0] vacant;

   // oldest entry sits at the highest occupied index
   always_comb begin
      sel_oh = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (valid_q[i]) begin
            sel_oh    = '0;
            sel_oh[i] = 1'b1;
         end
      end
      any_valid = |valid_q;
      take      = deq & any_valid;
   end

   // vacancy ripples from the output end back to the entry slot
   always_comb begin
      pop    = '0;
      mv     = '0;
      vacant = '0;
      vac_up = 1'b0;
      for (int i = TOP; i >= 0; i--) begin
         pop[i]    = take & sel_oh[i];
         mv[i]     = (i < TOP) ? (valid_q[i] & vac_up & ~pop[i]) : 1'b0;
         vacant[i] = ~valid_q[i] | pop[i] | mv[i];
         vac_up    = vacant[i];
      end
      full = ~vacant[0];
   end

   always_comb begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (flush)                    act[i] = SLOT_CLEAR;
         else if (i == 0)              act[i] = vacant[0] ? SLOT_LOAD : SLOT_HOLD;
         else if (mv[i-1])             act[i] = SLOT_LOAD;
         else if (pop[i] | mv[i])      act[i] = SLOT_CLEAR;
         else                          act[i] = SLOT_HOLD;
      end
   end
endmodule

// File: rtl/stq_oldest_mux.sv
module stq_oldest_mux #(
   parameter int DATA_W    = 8,
   parameter int NUM_SLOTS = 3
) (
   input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data,
   input  logic [NUM_SLOTS-1:0]             sel_oh,
   output logic [DATA_W-1:0]                dout
);
   always_comb begin
      dout = '0;
      for (int i = 0; i < NUM_SLOTS; i++)
         dout = dout | (slot_data[i] & {DATA_W{sel_oh[i]}});
   end
endmodule

// File: rtl/shift_token_queue.sv
module shift_token_queue
   import stq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_SLOTS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              full,
   input  logic              deq,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("shift_token_queue: DATA_W must be at least 1");
   end
   if (NUM_SLOTS < 2) begin : g_bad_depth
      $error("shift_token_queue: NUM_SLOTS must be at least 2");
   end

   logic [NUM_SLOTS-1:0]             valid_q;
   logic [NUM_SLOTS-1:0][DATA_W-1:0] data_q;
   logic [NUM_SLOTS-1:0]             sel_oh;
   slot_act_e [NUM_SLOTS-1:0]        act;

   stq_flow_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
      .valid_q   (valid_q),
      .deq       (deq),
      .flush     (flush),
      .sel_oh    (sel_oh),
      .any_valid (out_valid),
      .full      (full),
      .act       (act)
   );

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      if (g == 0) begin : g_entry
         stq_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .act      (act[g]),
            .ld_valid (in_valid),
            .ld_data  (in_data),
            .valid_q  (valid_q[g]),
            .data_q   (data_q[g])
         );
      end else begin : g_chain
         stq_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .act      (act[g]),
            .ld_valid (1'b1),
            .ld_data  (data_q[g-1]),
            .valid_q  (valid_q[g]),
            .data_q   (data_q[g])
         );
      end
   end

   stq_oldest_mux #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_mux (
      .slot_data (slot_data_w),
      .sel_oh    (sel_oh),
      .dout      (out_data)
   );

   logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data_w;
   assign slot_data_w = data_q;

   assert_full_three_R4: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (&valid_q));

   assert_no_overwrite_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush) |=> ((&valid_q) && $stable(data_q)));

   assert_head_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !deq && !flush) |=> (out_valid && $stable(out_data)));

   assert_empty_to_shown_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && in_valid && !flush) |=> (out_valid && out_data == $past(in_data)));

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);
endmodule

// File: tb/shift_token_queue_test.sv
module shift_token_queue_test;
   localparam int DW    = 12;
   localparam int DEPTH = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          deq = 1'b0;
   logic          full;
   logic          out_valid;
   logic [DW-1:0] out_data;

   int checks = 0;
   int fails  = 0;
   int mq[$];
   logic [DW-1:0] tok = 12'h100;

   always #2 clk = ~clk;

   shift_token_queue #(.DATA_W(DW), .NUM_SLOTS(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_data(in_data), .full(full),
      .deq(deq), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one cycle: drive, compare against model, advance model
   task automatic step(input bit iv, input bit dq, input bit fl, input string tag);
      bit exp_full;
      bit acc;
      @(negedge clk);
      in_valid = iv;
      in_data  = tok;
      deq      = dq;
      flush    = fl;
      #1;
      exp_full = (mq.size() == DEPTH) && !dq;
      check(out_valid == (mq.size() > 0), {tag, "/R9"}, "out_valid",
            int'(out_valid), int'(mq.size() > 0));
      if (mq.size() > 0)
         check(out_data == DW'(mq[0]), {tag, "/R2"}, "out_data",
               int'(out_data), mq[0]);
      check(full == exp_full, {tag, "/R5"}, "full", int'(full), int'(exp_full));
      if (fl) begin
         mq.delete();
      end else begin
         acc = iv && !exp_full;
         if (dq && mq.size() > 0) void'(mq.pop_front());
         if (acc) mq.push_back(int'(tok));
      end
      if (iv) tok = tok + 1'b1;
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      #1;
      check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
      check(full == 1'b0, "R1", "full", int'(full), 0);
      // R3: single token shown next cycle
      step(1, 0, 0, "R3");
      step(0, 0, 0, "R3");
      step(0, 1, 0, "R3");
      // R4: three tokens make the queue full
      step(1, 0, 0, "R4");
      step(1, 0, 0, "R4");
      step(1, 0, 0, "R4");
      step(0, 0, 0, "R4");
      // R6: offers while full are dropped, contents intact
      step(1, 0, 0, "R6");
      step(1, 0, 0, "R6");
      for (int k = 0; k < 4; k++) step(0, 1, 0, "R6");
      // R5: dequeue from full accepts a same-cycle token
      step(1, 0, 0, "R5");
      step(1, 0, 0, "R5");
      step(1, 0, 0, "R5");
      step(1, 1, 0, "R5");
      step(0, 0, 0, "R5");
      for (int k = 0; k < 4; k++) step(0, 1, 0, "R5");
      // R7: dequeue on an empty queue has no effect
      for (int k = 0; k < 3; k++) step(0, 1, 0, "R7");
      step(1, 1, 0, "R7");
      step(1, 0, 0, "R7");
      step(0, 0, 0, "R7");
      for (int k = 0; k < 3; k++) step(0, 1, 0, "R7");
      // R8: flush wins over a same-cycle write and dequeue
      step(1, 0, 0, "R8");
      step(1, 0, 0, "R8");
      step(1, 1, 1, "R8");
      step(0, 0, 0, "R8");
      step(1, 0, 0, "R8");
      step(0, 0, 0, "R8");
      step(0, 1, 0, "R8");
      // R2: random traffic, ordering and no loss or duplication
      for (int k = 0; k < 3000; k++)
         step(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 2) == 0),
              1'($urandom_range(0, 99) == 0), "R2");
      for (int k = 0; k < 4; k++) step(0, 1, 0, "R2");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule